// File: doc/BRIEF.md
# Double-Buffered Clock Register File

This block is the register side of a timekeeping function. A host reaches sixteen byte-wide registers over a parallel bus. The bus has active-low memory enable, select, write-enable and output-enable strobes and a 4-bit address. All strobes are sampled on the system clock through a synchronizer. A small state machine turns each bus cycle into a single-cycle commit pulse or an output-drive window.

The block keeps two copies of the time. The inner copy counts seconds, minutes and hours in BCD on a once-per-second tick. The outer copy is what the bus reads. On every clock the outer copy follows the inner one, unless the host has set a halt bit in the control register. The read-halt bit freezes the outer copy so that a multi-byte read is coherent. The write-halt bit turns the outer time registers into a staging area. Clearing write-halt then loads the staged time into the counter. An oscillator-stop bit, kept in bit 7 of the seconds register, makes the counter ignore ticks.

Register map: 0h is control (bit 0 read-halt, bit 1 write-halt, other bits read 0). 1h–7h are plain storage. 8h–Fh are the outer time registers: 9h holds seconds in bits 6:0 and oscillator-stop in bit 7, Ah holds minutes and Bh holds hours (00–23). 8h and Ch–Fh are held without counting.

States of the bus machine:
- IDLE
- READ
- WRITE
- RECOVER

Transitions of the bus machine:
- IDLE→WRITE on write-active.
- IDLE→READ on read-active.
- READ→WRITE when write-enable falls.
- READ→IDLE when select rises.
- WRITE→RECOVER when the write ends; this emits the commit.
- RECOVER→IDLE once write-enable has been high for REC_CYCLES clocks in a row.

Top module: `rtc_dbuf_regs`

## Requirements
- R1: After reset the control register, the storage registers, the time registers and oscillator-stop all read 00h, and `rdata_oe` is 0.
- R2: With `cs_n` low and `ce_n` and `we_n` high, the block is in a read cycle. It drives `rdata_oe` high while `oe_n` is low, and `rdata` shows the register that `addr` selects.
- R3: A write lasts while `ce_n` is high and both `cs_n` and `we_n` are low. It starts at the later falling strobe and ends at the earlier rising strobe. It stores `wdata` at `addr` once, at the end. With `ce_n` low, no write takes place. The bus must hold `addr` and `wdata` stable through the write.
- R4: If `we_n` falls during a read cycle, `rdata_oe` drops within four clocks.
- R5: After a write ends, any new bus cycle is ignored until `we_n` has been high for REC_CYCLES consecutive clocks.
- R6: Each `sec_tick` pulse advances the BCD seconds (9h). The seconds carry into minutes (Ah) at 59, and the minutes carry into hours (Bh) at 59. 23:59:59 wraps to 00:00:00.
- R7: While bit 7 of 9h is 1, ticks are ignored. Bit 7 is writable at any time and reads back in 9h.
- R8: While control bit 0 is 1, registers 8h–Fh hold the value from when it was set, and the inner count keeps advancing. After it is cleared, reads show the advanced count.
- R9: While control bit 1 is 1, writes to 8h–Fh are stored and ticks do not change them. Clearing the bit loads them into the counter, which continues from the loaded time.
- R10: While control bit 1 is 0, writes to 8h–Fh change nothing except bit 7 of 9h.
- R11: Registers 1h–7h store and return any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Memory enable, active low; must be high for register cycles |
| cs_n | input | 1 | Register select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | High when `rdata` should be driven onto the bus |
| sec_tick | input | 1 | One-clock pulse once per second |

## Verification
The hardest situation to reach is the recovery window. A second write has to land while the machine is still in RECOVER, and it must leave no trace. The stimulus ends one write with only two idle clocks and then starts another. A later read shows that the first value survived, and a write issued after a long gap shows that the machine left RECOVER. A write that begins inside a read cycle is reached by lowering `we_n` while select and output-enable stay low. The bench watches `rdata_oe` fall and then reads back the byte that this write stored.

// File: rtl/rtc_dbuf_pkg.sv
package rtc_dbuf_pkg;
    typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_RECOVER} bus_state_e;

    localparam int TIME_REGS = 8;
    localparam int SEC_IDX   = 1;
    localparam int MIN_IDX   = 2;
    localparam int HR_IDX    = 3;

    // Returns {wrapped, next} for a BCD value that counts 00..top
    function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] top);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = v[7:4] + 4'd1;
        lo = v[3:0] + 4'd1;
        if (v == top)
            return {1'b1, 8'h00};
        else if (v[3:0] == 4'd9)
            return {1'b0, hi, 4'd0};
        else
            return {1'b0, v[7:4], lo};
    endfunction
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= din;
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_dbuf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int REC_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          cs_s,
    input  logic          we_s,
    input  logic          oe_s,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_commit,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_oe
);
    localparam int CW = $clog2(REC_CYCLES + 1);

    bus_state_e state, nxt;
    logic [CW-1:0] rec_cnt;
    logic wr_act, rd_act;

    assign wr_act = ce_s && !cs_s && !we_s;
    assign rd_act = ce_s && !cs_s && we_s;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (wr_act) nxt = S_WRITE;
                       else if (rd_act) nxt = S_READ;
            S_READ:    if (wr_act) nxt = S_WRITE;
                       else if (!rd_act) nxt = S_IDLE;
            S_WRITE:   if (!wr_act) nxt = S_RECOVER;
            S_RECOVER: if (we_s && rec_cnt == CW'(REC_CYCLES - 1)) nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;

    // Outputs, recovery counter and write capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_cnt   <= '0;
            wr_commit <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            rd_oe     <= 1'b0;
        end else begin
            rec_cnt   <= (state == S_RECOVER && we_s) ? rec_cnt + 1'b1 : '0;
            wr_commit <= (state == S_WRITE) && !wr_act;
            rd_oe     <= (nxt == S_READ) && !oe_s;
            if (state == S_WRITE && wr_act) begin
                wr_addr <= addr;
                wr_data <= wdata;
            end
        end
    end

    assert_we_fall_drops_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_s) |=> !rd_oe);
    assert_no_commit_in_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECOVER && $past(state == S_RECOVER)) |-> !wr_commit);
    assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);
    assert_drive_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(!cs_s && !oe_s && ce_s));
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_dbuf_pkg::*;
#(
    parameter int NT = TIME_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   osc_stop,
    input  logic                   r_halt,
    input  logic                   w_halt,
    input  logic                   commit,
    input  logic                   stage_we,
    input  logic [$clog2(NT)-1:0]  stage_idx,
    input  logic [7:0]             stage_data,
    output logic [NT-1:0][7:0]     ext_q
);
    logic [NT-1:0][7:0] int_q;
    logic [8:0] sec_n, min_n, hr_n;

    assign sec_n = bcd_step({1'b0, int_q[SEC_IDX][6:0]}, 8'h59);
    assign min_n = bcd_step({1'b0, int_q[MIN_IDX][6:0]}, 8'h59);
    assign hr_n  = bcd_step({2'b0, int_q[HR_IDX][5:0]},  8'h23);

    // Inner counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '0;
        end else if (commit) begin
            int_q <= ext_q;
            int_q[SEC_IDX][7] <= 1'b0;
        end else if (tick && !osc_stop) begin
            int_q[SEC_IDX] <= sec_n[7:0];
            if (sec_n[8]) begin
                int_q[MIN_IDX] <= min_n[7:0];
                if (min_n[8]) int_q[HR_IDX] <= hr_n[7:0];
            end
        end
    end

    // Outer copy seen by the bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (!r_halt && !w_halt) begin
            ext_q <= int_q;
        end else if (w_halt && stage_we) begin
            ext_q[stage_idx] <= stage_data;
            if (int'(stage_idx) == SEC_IDX) ext_q[stage_idx][7] <= 1'b0;
        end
    end

    assert_stopped_seconds_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !commit) |=> $stable(int_q[SEC_IDX]));
    assert_read_halt_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_halt && !w_halt) |=> $stable(ext_q));
    assert_seconds_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !osc_stop && !commit && int_q[SEC_IDX][6:0] == 7'h59) |=> int_q[SEC_IDX][6:0] == 7'h00);
endmodule

// File: rtl/rtc_dbuf_regs.sv
module rtc_dbuf_regs
    import rtc_dbuf_pkg::*;
#(
    parameter int REC_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cs_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rdata_oe,
    input  logic       sec_tick
);
    localparam int SCR_N = 7;

    logic [3:0] strb_s;
    logic       wr_commit;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       r_halt, w_halt, osc_stop;
    logic       commit, stage_we;
    logic [7:0] scratch [SCR_N];
    logic [TIME_REGS-1:0][7:0] ext_q;

    rtc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({ce_n, cs_n, we_n, oe_n}), .dout(strb_s)
    );

    rtc_bus_fsm #(.AW(4), .DW(8), .REC_CYCLES(REC_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ce_s(strb_s[3]), .cs_s(strb_s[2]), .we_s(strb_s[1]), .oe_s(strb_s[0]),
        .addr(addr), .wdata(wdata),
        .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data), .rd_oe(rdata_oe)
    );

    assign commit   = wr_commit && wr_addr == 4'h0 && w_halt && !wr_data[1];
    assign stage_we = wr_commit && wr_addr[3];

    rtc_time_core #(.NT(TIME_REGS)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .osc_stop(osc_stop),
        .r_halt(r_halt), .w_halt(w_halt), .commit(commit),
        .stage_we(stage_we), .stage_idx(wr_addr[2:0]), .stage_data(wr_data),
        .ext_q(ext_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_halt   <= 1'b0;
            w_halt   <= 1'b0;
            osc_stop <= 1'b0;
            for (int i = 0; i < SCR_N; i++) scratch[i] <= '0;
        end else if (wr_commit) begin
            if (wr_addr == 4'h0) begin
                r_halt <= wr_data[0];
                w_halt <= wr_data[1];
            end else if (!wr_addr[3]) begin
                scratch[wr_addr[2:0] - 3'd1] <= wr_data;
            end else if (wr_addr == 4'h9) begin
                osc_stop <= wr_data[7];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata <= '0;
        else if (addr == 4'h0)     rdata <= {6'b0, w_halt, r_halt};
        else if (!addr[3])         rdata <= scratch[addr[2:0] - 3'd1];
        else if (addr == 4'h9)     rdata <= ext_q[SEC_IDX] | {osc_stop, 7'b0};
        else                       rdata <= ext_q[addr[2:0]];
    end

    assert_commit_clears_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !w_halt);
    assert_no_commit_when_ce_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_s[3] && $past(!strb_s[3]) && $past(!strb_s[3], 2)) |-> !wr_commit);
endmodule

// File: tb/rtc_dbuf_regs_bench.sv
module rtc_dbuf_regs_bench;
    localparam int REC = 8;

    logic clk = 0, rst_n = 0;
    logic ce_n = 1, cs_n = 1, we_n = 1, oe_n = 1, sec_tick = 0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rdata_oe;
    int checks = 0, fails = 0;

    typedef struct {
        logic [7:0] exp;
        logic       oe_exp;
        logic       chk_data;
        string      req;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;  // 50 MHz

    rtc_dbuf_regs #(.REC_CYCLES(REC)) u_rtc_dbuf_regs (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .sec_tick(sec_tick)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Monitor: pops expected items and compares
    initial forever begin
        @(negedge clk);
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (rdata_oe !== it.oe_exp || (it.chk_data && rdata !== it.exp)) begin
                fails++;
                $display("FAIL %s: rdata=%h oe=%b expected rdata=%h oe=%b",
                         it.req, rdata, rdata_oe, it.exp, it.oe_exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input logic ce, input int gap);
        @(negedge clk);
        addr = a; wdata = d; ce_n = ce; cs_n = 0; we_n = 0;
        repeat (5) @(negedge clk);
        we_n = 1; cs_n = 1;
        repeat (4) @(negedge clk);
        ce_n = 1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string req);
        item_t it;
        @(negedge clk);
        addr = a; cs_n = 0; oe_n = 0;
        repeat (6) @(negedge clk);
        it.exp = e; it.oe_exp = 1'b1; it.chk_data = 1'b1; it.req = req;
        q.push_back(it);
        repeat (2) @(negedge clk);
        cs_n = 1; oe_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1;
            @(negedge clk); sec_tick = 0;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        item_t it;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (rdata_oe !== 1'b0) begin fails++; $display("FAIL R1: oe=%b expected 0", rdata_oe); end
        bus_read(4'h0, 8'h00, "R1 control");
        bus_read(4'h9, 8'h00, "R1 seconds");
        bus_read(4'h2, 8'h00, "R1 storage");

        // R11, R3, R2: storage write and read
        bus_write(4'h3, 8'hA5, 1'b1, 16);
        bus_write(4'h7, 8'h3C, 1'b1, 16);
        bus_read(4'h3, 8'hA5, "R11 reg3");
        bus_read(4'h7, 8'h3C, "R2 reg7");
        // R3: memory enable low blocks the write
        bus_write(4'h3, 8'hFF, 1'b0, 16);
        bus_read(4'h3, 8'hA5, "R3 ce low");

        // R5: write inside recovery window is ignored
        bus_write(4'h4, 8'h11, 1'b1, 2);
        bus_write(4'h4, 8'h22, 1'b1, 20);
        bus_read(4'h4, 8'h11, "R5 ignored");
        bus_write(4'h4, 8'h33, 1'b1, 16);
        bus_read(4'h4, 8'h33, "R5 after recovery");

        // R6: ticks advance seconds
        tick(3);
        bus_read(4'h9, 8'h03, "R6 count");

        // R9: stage and commit a time
        bus_write(4'h0, 8'h02, 1'b1, 16);
        bus_write(4'h9, 8'h58, 1'b1, 16);
        bus_write(4'hA, 8'h59, 1'b1, 16);
        bus_write(4'hB, 8'h23, 1'b1, 16);
        bus_write(4'hE, 8'h42, 1'b1, 16);
        tick(2);
        bus_read(4'h9, 8'h58, "R9 staged hold");
        bus_read(4'h0, 8'h02, "R9 control");
        bus_write(4'h0, 8'h00, 1'b1, 16);
        bus_read(4'hA, 8'h59, "R9 committed min");
        bus_read(4'hE, 8'h42, "R9 committed other");
        // R6: wrap 23:59:58 -> 23:59:59 -> 00:00:00
        tick(1);
        bus_read(4'h9, 8'h59, "R6 59");
        tick(1);
        bus_read(4'h9, 8'h00, "R6 wrap sec");
        bus_read(4'hA, 8'h00, "R6 wrap min");
        bus_read(4'hB, 8'h00, "R6 wrap hr");

        // R10: time write without write-halt ignored
        bus_write(4'hA, 8'h12, 1'b1, 16);
        bus_read(4'hA, 8'h00, "R10 ignored");

        // R7: oscillator stop
        bus_write(4'h9, 8'h80, 1'b1, 16);
        tick(3);
        bus_read(4'h9, 8'h80, "R7 stopped");
        bus_write(4'h9, 8'h00, 1'b1, 16);
        tick(1);
        bus_read(4'h9, 8'h01, "R7 running");

        // R8: read-halt snapshot
        bus_write(4'h0, 8'h01, 1'b1, 16);
        tick(4);
        bus_read(4'h9, 8'h01, "R8 frozen");
        bus_read(4'h0, 8'h01, "R8 control");
        bus_write(4'h0, 8'h00, 1'b1, 16);
        bus_read(4'h9, 8'h05, "R8 resumed");

        // R4: write enable falling during a read drops the output
        @(negedge clk);
        addr = 4'h5; wdata = 8'h77; cs_n = 0; oe_n = 0;
        repeat (6) @(negedge clk);
        it.exp = 8'h00; it.oe_exp = 1'b1; it.chk_data = 1'b1; it.req = "R2 driving";
        q.push_back(it);
        repeat (2) @(negedge clk);
        we_n = 0;
        repeat (4) @(negedge clk);
        it.exp = 8'h00; it.oe_exp = 1'b0; it.chk_data = 1'b0; it.req = "R4 output off";
        q.push_back(it);
        repeat (2) @(negedge clk);
        we_n = 1; cs_n = 1; oe_n = 1;
        repeat (20) @(negedge clk);
        bus_read(4'h5, 8'h77, "R4 write landed");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule